// File: doc/BRIEF.md
# Two-Level Nested Interrupt Acknowledge Controller

This block decides which maskable interrupt request a CPU takes, and when it takes it. Each request source has its own request flag, its own mask bit and a one-bit level: 0 selects the high level and 1 selects the low level. The controller holds the global enable flag and the in-service level flag. The in-service level flag reads 0 while a high-level handler runs. It reads 1 when nothing is being serviced or when only a low-level handler runs. A software interrupt request is also latched. It bypasses both flags.

The CPU strobes `boundary_i` each time an instruction completes. The controller grants only on such a strobe. It then issues a one-cycle acknowledge together with the vector of the chosen source, and it clears that source's request flag. The CPU drives set-enable and clear-enable events and a return event. The return event carries the flag values that were stacked before the handler. After a return, at least one main-program instruction must complete before any further grant. Arbitration runs in one of two orders, chosen at run time: a fixed order by source index, or a programmable order in which the level decides first.

Top module: `nest_irq_ack`

## Requirements
- R1: After reset the global enable flag is 0, the in-service level flag is 1, all request flags are 0 and the acknowledge output is low.
- R2: A request pulse sets that source's request flag. The flag stays set, whatever the mask, enable and level state, until the source is granted.
- R3: A masked source is never granted while it stays masked. Once it is unmasked, its latched request can be granted.
- R4: `ack_o` rises for exactly the cycle after a clock edge at which `boundary_i` was high. It never rises after an edge without that strobe.
- R5: A maskable source can be granted only while the global enable flag is 1. A source at level 0 can be granted at either in-service level. A source at level 1 can be granted only while the in-service level flag is 1.
- R6: When a maskable source is granted, the global enable flag is cleared, the in-service level flag is loaded with that source's level, and the source's request flag is cleared, all at the granting edge.
- R7: With `ord_prog_i` = 1, an eligible level-0 source is preferred over any level-1 source, and ties go to the lowest index. `ack_vec_o` equals the granted source index.
- R8: With `ord_prog_i` = 0, the eligible source with the lowest index is granted regardless of its level.
- R9: A pending software request is granted at the next boundary whatever the two flags hold, and it takes precedence over every maskable source. Its vector is N_SRC. Its grant clears the global enable flag and leaves the in-service level flag unchanged.
- R10: In one edge the global enable flag is updated by the first applicable cause in this order: grant clears it, return loads `ret_en_i`, clear-enable clears it, set-enable sets it.
- R11: A return event loads both flags from `ret_en_i` and `ret_svc_low_i`. No grant happens at the edge of the return or at the first boundary edge after it. Grants are possible again from the second boundary edge.
- R12: If a source is requested at the same edge at which it is granted, its request flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | N_SRC | Request pulses, one per source |
| src_mask_i | input | N_SRC | 1 masks the source |
| src_low_i | input | N_SRC | Source level: 0 high, 1 low |
| ord_prog_i | input | 1 | 1 selects programmable order, 0 selects fixed order |
| soft_req_i | input | 1 | Software interrupt request pulse |
| en_set_i | input | 1 | Set-enable event |
| en_clr_i | input | 1 | Clear-enable event |
| ret_i | input | 1 | Return-from-interrupt event |
| ret_en_i | input | 1 | Enable flag value restored on return |
| ret_svc_low_i | input | 1 | In-service level flag value restored on return |
| boundary_i | input | 1 | Instruction-completed strobe |
| ack_o | output | 1 | One-cycle acknowledge pulse |
| ack_vec_o | output | $clog2(N_SRC+1) | Granted vector: source index, or N_SRC for software |
| glb_en_o | output | 1 | Global enable flag |
| svc_low_o | output | 1 | In-service level flag |
| pend_o | output | N_SRC+1 | Request flags; bit N_SRC is the software request |

## Verification
The bench builds the controller with N_SRC = 5. With that value the software vector (5) sits just above the maskable indices, and the vector field is a non-power-of-two 3-bit code. It also leaves the sources few enough that random request bursts often hit several of them in the same cycle. That regularly pits level-0 sources against level-1 sources of lower index in both arbitration orders, and it keeps masked, blocked and post-return pending flags under frequent load.

// File: rtl/nia_pkg.sv
`timescale 1ns/1ps
package nia_pkg;

   // Cause that drives the flag update at one edge, highest first
   typedef enum logic [2:0] {
      FU_HOLD    = 3'd0,
      FU_TAKE_HW = 3'd1,
      FU_TAKE_SW = 3'd2,
      FU_RESTORE = 3'd3,
      FU_DISABLE = 3'd4,
      FU_ENABLE  = 3'd5
   } flag_upd_e;

endpackage

// File: rtl/nia_pick.sv
`timescale 1ns/1ps
// Find-first: lowest set index of a request vector
module nia_pick #(
   parameter int W  = 8,
   parameter int IW = 3
) (
   input  logic [W-1:0]  req_i,
   output logic          hit_o,
   output logic [IW-1:0] idx_o
);

   if (W < 1) begin : g_bad_w
      $error("nia_pick: W must be at least 1");
   end
   if ((1 << IW) < W) begin : g_bad_iw
      $error("nia_pick: IW too narrow for W");
   end

   always_comb begin
      hit_o = |req_i;
      idx_o = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IW'(i);
      end
   end

endmodule

// File: rtl/nia_pend.sv
`timescale 1ns/1ps
// Bank of sticky request flags; set wins over clear
module nia_pend #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q <= 1'b0;
         else        flag_q <= (flag_q & ~clr_i[b]) | set_i[b];
      end
      assign q_o[b] = flag_q;
   end

endmodule

// File: rtl/nia_arb.sv
`timescale 1ns/1ps
// Eligibility filter and two-order arbiter
module nia_arb #(
   parameter int N_SRC = 8,
   parameter int VEC_W = 4
) (
   input  logic [N_SRC-1:0] pend_i,
   input  logic             soft_i,
   input  logic [N_SRC-1:0] mask_i,
   input  logic [N_SRC-1:0] low_i,
   input  logic             glb_en_i,
   input  logic             svc_low_i,
   input  logic             ord_prog_i,
   output logic             hit_o,
   output logic [VEC_W-1:0] idx_o
);

   logic [N_SRC-1:0] elig;
   logic [N_SRC-1:0] elig_hi;
   logic             any_hit, hi_hit;
   logic [VEC_W-1:0] any_idx, hi_idx;

   assign elig    = pend_i & ~mask_i & {N_SRC{glb_en_i}} & (~low_i | {N_SRC{svc_low_i}});
   assign elig_hi = elig & ~low_i;

   nia_pick #(.W(N_SRC), .IW(VEC_W)) u_pick_any (
      .req_i (elig),
      .hit_o (any_hit),
      .idx_o (any_idx)
   );

   nia_pick #(.W(N_SRC), .IW(VEC_W)) u_pick_hi (
      .req_i (elig_hi),
      .hit_o (hi_hit),
      .idx_o (hi_idx)
   );

   always_comb begin
      hit_o = soft_i | any_hit;
      if (soft_i)                 idx_o = VEC_W'(N_SRC);
      else if (ord_prog_i && hi_hit) idx_o = hi_idx;
      else                        idx_o = any_idx;
   end

endmodule

// File: rtl/nest_irq_ack.sv
`timescale 1ns/1ps
module nest_irq_ack
   import nia_pkg::*;
#(
   parameter  int N_SRC = 8,
   localparam int VEC_W = $clog2(N_SRC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_req_i,
   input  logic [N_SRC-1:0] src_mask_i,
   input  logic [N_SRC-1:0] src_low_i,
   input  logic             ord_prog_i,
   input  logic             soft_req_i,
   input  logic             en_set_i,
   input  logic             en_clr_i,
   input  logic             ret_i,
   input  logic             ret_en_i,
   input  logic             ret_svc_low_i,
   input  logic             boundary_i,
   output logic             ack_o,
   output logic [VEC_W-1:0] ack_vec_o,
   output logic             glb_en_o,
   output logic             svc_low_o,
   output logic [N_SRC:0]   pend_o
);

   localparam int PW = N_SRC + 1;

   if (N_SRC < 1 || N_SRC > 64) begin : g_bad_nsrc
      $error("nest_irq_ack: N_SRC must lie in 1..64");
   end

   logic [PW-1:0]    pend_q;
   logic [PW-1:0]    pend_clr;
   logic             en_q, low_q, hold_q;
   logic             en_d, low_d;
   logic             ack_q;
   logic [VEC_W-1:0] vec_q;
   logic             arb_hit;
   logic [VEC_W-1:0] arb_idx;
   logic             may_take, grant, take_soft, gr_low;
   flag_upd_e        upd;

   nia_pend #(.W(PW)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i ({soft_req_i, irq_req_i}),
      .clr_i (pend_clr),
      .q_o   (pend_q)
   );

   nia_arb #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_arb (
      .pend_i     (pend_q[N_SRC-1:0]),
      .soft_i     (pend_q[N_SRC]),
      .mask_i     (src_mask_i),
      .low_i      (src_low_i),
      .glb_en_i   (en_q),
      .svc_low_i  (low_q),
      .ord_prog_i (ord_prog_i),
      .hit_o      (arb_hit),
      .idx_o      (arb_idx)
   );

   // Grants only at a boundary, never at a return, never while held
   assign may_take  = boundary_i & ~ret_i & ~hold_q;
   assign grant     = may_take & arb_hit;
   assign take_soft = (arb_idx == VEC_W'(N_SRC));
   assign gr_low    = |(src_low_i & (N_SRC'(1) << arb_idx));
   assign pend_clr  = grant ? (PW'(1) << arb_idx) : '0;

   always_comb begin
      if (grant)         upd = take_soft ? FU_TAKE_SW : FU_TAKE_HW;
      else if (ret_i)    upd = FU_RESTORE;
      else if (en_clr_i) upd = FU_DISABLE;
      else if (en_set_i) upd = FU_ENABLE;
      else               upd = FU_HOLD;
   end

   always_comb begin
      en_d  = en_q;
      low_d = low_q;
      case (upd)
         FU_TAKE_HW: begin
            en_d  = 1'b0;
            low_d = gr_low;
         end
         FU_TAKE_SW: en_d = 1'b0;
         FU_RESTORE: begin
            en_d  = ret_en_i;
            low_d = ret_svc_low_i;
         end
         FU_DISABLE: en_d = 1'b0;
         FU_ENABLE:  en_d = 1'b1;
         default:    ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         low_q  <= 1'b1;
         hold_q <= 1'b0;
         ack_q  <= 1'b0;
         vec_q  <= '0;
      end else begin
         en_q  <= en_d;
         low_q <= low_d;
         ack_q <= grant;
         if (grant) vec_q <= arb_idx;
         if (ret_i)           hold_q <= 1'b1;
         else if (boundary_i) hold_q <= 1'b0;
      end
   end

   assign ack_o     = ack_q;
   assign ack_vec_o = vec_q;
   assign glb_en_o  = en_q;
   assign svc_low_o = low_q;
   assign pend_o    = pend_q;

endmodule

// File: rtl/nest_irq_ack_chk.sv
`timescale 1ns/1ps
module nest_irq_ack_chk #(
   parameter int N_SRC = 8,
   parameter int VEC_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] src_mask_i,
   input logic             en_set_i,
   input logic             en_clr_i,
   input logic             ret_i,
   input logic             ret_en_i,
   input logic             ret_svc_low_i,
   input logic             boundary_i,
   input logic             ack_o,
   input logic [VEC_W-1:0] ack_vec_o,
   input logic             glb_en_o,
   input logic             svc_low_o
);

   logic [N_SRC-1:0] mask_d;
   logic             mask_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_d <= '0;
      else        mask_d <= src_mask_i;
   end

   assign mask_hit = |(mask_d & (N_SRC'(1) << ack_vec_o));

   p_ack_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> $past(boundary_i));

   p_ack_vec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (ack_vec_o <= VEC_W'(N_SRC)));

   p_ack_clears_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> !glb_en_o);

   p_masked_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && (ack_vec_o < VEC_W'(N_SRC))) |-> !mask_hit);

   p_ret_no_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ret_i |=> !ack_o);

   p_ret_restore_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ret_i |=> (glb_en_o == $past(ret_en_i)) && (svc_low_o == $past(ret_svc_low_i)));

   p_dis_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_clr_i && !ret_i) |=> !glb_en_o);

   p_en_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_set_i && !en_clr_i && !ret_i) |=> (glb_en_o || ack_o));

endmodule

bind nest_irq_ack nest_irq_ack_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .src_mask_i    (src_mask_i),
   .en_set_i      (en_set_i),
   .en_clr_i      (en_clr_i),
   .ret_i         (ret_i),
   .ret_en_i      (ret_en_i),
   .ret_svc_low_i (ret_svc_low_i),
   .boundary_i    (boundary_i),
   .ack_o         (ack_o),
   .ack_vec_o     (ack_vec_o),
   .glb_en_o      (glb_en_o),
   .svc_low_o     (svc_low_o)
);

// File: tb/nest_irq_ack_test.sv
`timescale 1ns/1ps
module nest_irq_ack_test;

   localparam int N  = 5;
   localparam int VW = $clog2(N + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_req = '0, src_mask = '0, src_low = 5'b01010;
   logic          ord_prog = 1'b1, soft_req = 1'b0;
   logic          en_set = 1'b0, en_clr = 1'b0, ret = 1'b0;
   logic          ret_en = 1'b0, ret_svc_low = 1'b0, boundary = 1'b1;
   logic          ack;
   logic [VW-1:0] ack_vec;
   logic          glb_en, svc_low;
   logic [N:0]    pend;

   int checks = 0, errors = 0, cycles = 0;
   bit cmp_on = 1'b0;

   // reference state
   bit       m_en = 0, m_low = 1, m_hold = 0, m_ack = 0;
   int       m_vec = 0;
   bit [N:0] m_pend = '0;

   nest_irq_ack #(.N_SRC(N)) uut (
      .clk (clk), .rst_n (rst_n), .irq_req_i (irq_req), .src_mask_i (src_mask),
      .src_low_i (src_low), .ord_prog_i (ord_prog), .soft_req_i (soft_req),
      .en_set_i (en_set), .en_clr_i (en_clr), .ret_i (ret), .ret_en_i (ret_en),
      .ret_svc_low_i (ret_svc_low), .boundary_i (boundary), .ack_o (ack),
      .ack_vec_o (ack_vec), .glb_en_o (glb_en), .svc_low_o (svc_low), .pend_o (pend)
   );

   always #10 clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic bit can_go(int i);
      return m_pend[i] && !src_mask[i] && m_en && (!src_low[i] || m_low);
   endfunction

   // behavioural reference, updated at each rising edge
   always @(posedge clk) begin
      int g;
      bit [N:0] clr;
      if (!rst_n) begin
         m_en = 0; m_low = 1; m_hold = 0; m_ack = 0; m_vec = 0; m_pend = '0;
      end else begin
         g = -1;
         if (boundary && !ret && !m_hold) begin
            if (m_pend[N]) g = N;
            else begin
               for (int i = 0; i < N; i++)
                  if (g < 0 && can_go(i) && (!ord_prog || !src_low[i])) g = i;
               if (g < 0)
                  for (int i = 0; i < N; i++)
                     if (g < 0 && can_go(i)) g = i;
            end
         end
         clr = '0;
         if (g >= 0) clr[g] = 1'b1;
         if (g >= 0) begin
            if (g < N) m_low = src_low[g];
            m_en = 0;
         end else if (ret) begin
            m_en = ret_en; m_low = ret_svc_low;
         end else if (en_clr) m_en = 0;
         else if (en_set) m_en = 1;
         if (ret) m_hold = 1;
         else if (boundary) m_hold = 0;
         m_pend = (m_pend & ~clr) | {soft_req, irq_req};
         m_ack = (g >= 0);
         if (g >= 0) m_vec = g;
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      cycles++;
      if (cmp_on) begin
         chk("R4 ack pulse", int'(ack), int'(m_ack));
         if (m_ack) chk("R7 vector", int'(ack_vec), m_vec);
         chk("R10 enable flag", int'(glb_en), int'(m_en));
         chk("R11 in-service level", int'(svc_low), int'(m_low));
         chk("R2 request flags", int'(pend), int'(m_pend));
      end
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cycles, 100000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      cmp_on = 1'b1;
      // R1 reset state
      chk("R1 enable after reset", int'(glb_en), 0);
      chk("R1 level after reset", int'(svc_low), 1);
      chk("R1 ack after reset", int'(ack), 0);
      chk("R1 flags after reset", int'(pend), 0);

      // R5: enable flag clear blocks the grant, request stays latched
      irq_req = 5'b00010; tick(); irq_req = '0;
      chk("R2 src1 latched", int'(pend[1]), 1);
      tick();
      chk("R5 no grant while disabled", int'(ack), 0);
      // R6: enable then grant of level-1 source 1
      en_set = 1; tick(); en_set = 0;
      chk("R10 enable set", int'(glb_en), 1);
      tick();
      chk("R6 grant", int'(ack), 1);
      chk("R6 vector", int'(ack_vec), 1);
      chk("R6 enable cleared", int'(glb_en), 0);
      chk("R6 level loaded", int'(svc_low), 1);
      chk("R6 flag cleared", int'(pend[1]), 0);
      // level-0 grant makes in-service level 0
      en_set = 1; irq_req = 5'b00001; tick(); en_set = 0; irq_req = '0;
      tick();
      chk("R6 vector src0", int'(ack_vec), 0);
      chk("R6 level loaded 0", int'(svc_low), 0);
      // R5: low source blocked under high handler, equal level accepted
      en_set = 1; irq_req = 5'b01000; tick(); en_set = 0; irq_req = '0;
      tick();
      chk("R5 low blocked", int'(ack), 0);
      chk("R5 low kept pending", int'(pend[3]), 1);
      irq_req = 5'b10000; tick(); irq_req = '0;
      tick();
      chk("R5 equal level grant", int'(ack), 1);
      chk("R5 equal level vector", int'(ack_vec), 4);
      // R11: return restores flags, one boundary held
      ret = 1; ret_en = 1; ret_svc_low = 1; tick(); ret = 0;
      chk("R11 restored enable", int'(glb_en), 1);
      chk("R11 restored level", int'(svc_low), 1);
      chk("R11 no ack at return", int'(ack), 0);
      tick();
      chk("R11 no ack first boundary", int'(ack), 0);
      tick();
      chk("R11 ack second boundary", int'(ack), 1);
      chk("R11 vector src3", int'(ack_vec), 3);
      // R4: no boundary, no grant
      boundary = 0; en_set = 1; irq_req = 5'b00001; tick(); en_set = 0; irq_req = '0;
      tick();
      chk("R4 no boundary a", int'(ack), 0);
      tick();
      chk("R4 no boundary b", int'(ack), 0);
      boundary = 1; tick();
      chk("R4 boundary grant", int'(ack_vec), 0);
      // R7: programmable order prefers level 0 (src2 over src1)
      ret = 1; ret_en = 0; ret_svc_low = 1; irq_req = 5'b00110; tick(); ret = 0; irq_req = '0;
      tick();
      en_set = 1; ord_prog = 1; tick(); en_set = 0;
      tick();
      chk("R7 prog order vector", int'(ack_vec), 2);
      chk("R7 prog order ack", int'(ack), 1);
      // R8: fixed order takes lowest index (src1)
      ret = 1; ret_en = 0; ret_svc_low = 1; irq_req = 5'b00100; tick(); ret = 0; irq_req = '0;
      tick();
      en_set = 1; ord_prog = 0; tick(); en_set = 0;
      tick();
      chk("R8 fixed order vector", int'(ack_vec), 1);
      // R9: software request ignores flags, wins over maskable
      soft_req = 1; tick(); soft_req = 0;
      tick();
      chk("R9 soft ack", int'(ack), 1);
      chk("R9 soft vector", int'(ack_vec), N);
      chk("R9 level unchanged", int'(svc_low), 1);
      en_set = 1; soft_req = 1; tick(); en_set = 0; soft_req = 0;
      tick();
      chk("R9 soft precedence", int'(ack_vec), N);
      chk("R9 enable cleared", int'(glb_en), 0);
      chk("R9 maskable kept", int'(pend[2]), 1);
      // R12: request at the granting edge stays set
      en_set = 1; tick(); en_set = 0; irq_req = 5'b00100; tick(); irq_req = '0;
      chk("R12 grant src2", int'(ack_vec), 2);
      chk("R12 flag re-set", int'(pend[2]), 1);
      // R3: masked source never granted, served after unmask
      src_mask = 5'b00100; en_set = 1; tick(); en_set = 0;
      tick();
      chk("R3 masked no ack", int'(ack), 0);
      chk("R3 masked latched", int'(pend[2]), 1);
      tick();
      chk("R3 still masked", int'(ack), 0);
      src_mask = '0; tick();
      chk("R3 after unmask", int'(ack_vec), 2);

      // random phase against the reference model
      for (int k = 0; k < 4000; k++) begin
         tick();
         irq_req  = ($urandom % 5 == 0) ? N'($urandom) : '0;
         if ($urandom % 60 == 0) src_mask = N'($urandom) & N'($urandom);
         if ($urandom % 80 == 0) src_low  = N'($urandom);
         if ($urandom % 90 == 0) ord_prog = ~ord_prog;
         soft_req = ($urandom % 40 == 0);
         en_set   = ($urandom % 4 == 0);
         en_clr   = ($urandom % 14 == 0);
         ret      = ($urandom % 12 == 0);
         ret_en   = 1'($urandom);
         ret_svc_low = 1'($urandom);
         boundary = ($urandom % 4 != 0);
      end
      tick();
      irq_req = '0; soft_req = 0; en_set = 0; en_clr = 0; ret = 0;
      tick();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule